// File: doc/BRIEF.md
# Link-Side Receive Deframer

This block sits in the link controller and watches the two control lines and the eight data lines driven by the physical-layer device. When the control lines switch to Receive while every data line is high, a packet is on its way. The first symbol that is not all ones carries the speed code. The deframer decodes it, holds it as the packet's speed and keeps it out of the payload. Every symbol after that adds 2, 4 or 8 bits, depending on the speed. The bits are packed most-significant first into 32-bit quadlets.

Quadlets leave on a registered stream with a valid strobe. The final quadlet of a packet carries a last strobe. A trailing quadlet that is only partly filled is emitted with a short flag. A packet with no payload produces a one-cycle null-packet pulse instead of a quadlet. A speed code that is not recognized produces a one-cycle error pulse, and the rest of that packet is discarded.

The controller is a four-state machine. IDLE waits for data-on and moves to PREFIX on Receive with all ones. PREFIX stays in PREFIX while data-on lasts. From PREFIX it takes one of three transitions: to PAYLOAD on a valid speed code, to DISCARD on an unknown code, or back to IDLE (null packet) when Receive ends. PAYLOAD returns to IDLE when Receive ends. DISCARD returns to IDLE when Receive ends.

Top module: `lnk_rx_deframer`

## Requirements
- R1: In the idle state, a Receive control value (`ctl_i` = 2'b10) with data other than 8'hFF starts nothing. It produces no quadlet, no null pulse and no error pulse.
- R2: The first non-8'hFF symbol after data-on is the speed code, with `d_i[7]` carrying line D0. 8'h00 gives `spd_o` = 0 (S100), 8'h40 gives 1 (S200) and 8'h50 gives 2 (S400). `spd_o` holds that value until the next packet's code is decoded.
- R3: Neither the data-on symbols nor the speed-code symbol appear in the quadlet stream.
- R4: Each Receive cycle after the speed code contributes `d_i[7:6]` at S100, `d_i[7:4]` at S200 and `d_i[7:0]` at S400. The bits are packed MSB-first, so the first payload bit lands in `q_data_o[31]`.
- R5: Each filled quadlet is emitted with `q_valid_o`. The packet's final quadlet carries `q_last_o`, registered on the clock edge that follows the first non-Receive cycle.
- R6: If the payload ends part-way through a quadlet, the trailing bits are emitted left-justified and zero-padded, with `q_last_o` and `q_short_o` both set. A complete final quadlet has `q_short_o` clear.
- R7: A packet that ends with no payload bits, either straight after data-on or straight after the speed code, raises `null_pkt_o` for one cycle on the edge after Receive ends, and emits no quadlet.
- R8: An unrecognized speed code raises `spd_err_o` for one cycle. No quadlet or null pulse follows until Receive ends, and the next packet is handled normally.
- R9: After reset, `q_valid_o`, `q_last_o`, `q_short_o`, `null_pkt_o`, `spd_err_o` and `spd_o` are all zero.
- R10: Any control value other than Receive ends a packet, not only Idle (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_i | input | 2 | Control lines from the physical layer (2'b10 = Receive) |
| d_i | input | 8 | Data lines, d_i[7] = D0 |
| q_data_o | output | 32 | Assembled quadlet |
| q_valid_o | output | 1 | Quadlet strobe |
| q_last_o | output | 1 | Final quadlet of the packet |
| q_short_o | output | 1 | Final quadlet was only partly filled |
| null_pkt_o | output | 1 | Packet with no payload ended |
| spd_err_o | output | 1 | Unrecognized speed code |
| spd_o | output | 2 | Speed of the current packet (0 S100, 1 S200, 2 S400) |

## Verification
The bench builds the block with its default parameters: 32-bit quadlets and 8-bit symbols. With these values all three bit widths divide the quadlet evenly, so at each speed a packet can end exactly on a quadlet boundary or in any legal partial fill. This makes every short-quadlet fill reachable: 2 to 30 bits at S100, 4 to 28 bits at S200 and 8 to 24 bits at S400. Packets of up to 40 symbols also keep a completed quadlet held back while the next one fills, across several quadlets per packet.

// File: rtl/lnk_rx_pkg.sv
package lnk_rx_pkg;

    typedef enum logic [1:0] {
        SPD_S100 = 2'd0,
        SPD_S200 = 2'd1,
        SPD_S400 = 2'd2,
        SPD_BAD  = 2'd3
    } spd_e;

    localparam logic [1:0] CTL_RECEIVE = 2'b10;
    localparam logic [7:0] SYM_DATA_ON = 8'hFF;
    localparam logic [7:0] CODE_S100   = 8'h00;
    localparam logic [7:0] CODE_S200   = 8'h40;
    localparam logic [7:0] CODE_S400   = 8'h50;

    // bits carried per symbol at a given speed
    function automatic int unsigned spd_bits(spd_e s);
        case (s)
            SPD_S100: return 2;
            SPD_S200: return 4;
            default:  return 8;
        endcase
    endfunction

endpackage

// File: rtl/lnk_rx_spd_dec.sv
module lnk_rx_spd_dec
    import lnk_rx_pkg::*;
#(
    parameter int SYM_W = 8
) (
    input  logic [SYM_W-1:0] sym_i,
    output spd_e             spd_o
);
    localparam int PAD_W = SYM_W - 8;

    logic [7:0] code;

    generate
        if (PAD_W > 0) begin : g_wide
            assign code = sym_i[SYM_W-1 -: 8];
        end else begin : g_exact
            assign code = sym_i[7:0];
        end
    endgenerate

    always_comb begin
        unique case (code)
            CODE_S100: spd_o = SPD_S100;
            CODE_S200: spd_o = SPD_S200;
            CODE_S400: spd_o = SPD_S400;
            default:   spd_o = SPD_BAD;
        endcase
    end
endmodule

// File: rtl/lnk_rx_packer.sv
module lnk_rx_packer #(
    parameter int QUAD_W = 32,
    parameter int SYM_W  = 8,
    parameter int CNT_W  = $clog2(QUAD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              sym_en_i,
    input  logic [CNT_W-1:0]  nbits_i,
    input  logic [SYM_W-1:0]  sym_i,
    input  logic              fin_i,
    output logic              empty_o,
    output logic [QUAD_W-1:0] q_data_o,
    output logic              q_valid_o,
    output logic              q_last_o,
    output logic              q_short_o
);
    localparam int            PAD_W  = QUAD_W - SYM_W;
    localparam logic [CNT_W-1:0] FULL   = CNT_W'(QUAD_W);
    localparam logic [CNT_W-1:0] SYMW_C = CNT_W'(SYM_W);

    logic [QUAD_W-1:0] acc_q, hold_q, acc_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              hold_v_q;
    logic [SYM_W-1:0]  sym_top;

    // top nbits_i bits of the symbol, right-aligned
    assign sym_top = sym_i >> (SYMW_C - nbits_i);
    assign acc_n   = (acc_q << nbits_i) | {{PAD_W{1'b0}}, sym_top};
    assign cnt_n   = cnt_q + nbits_i;
    assign empty_o = !hold_v_q && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            hold_q    <= '0;
            cnt_q     <= '0;
            hold_v_q  <= 1'b0;
            q_data_o  <= '0;
            q_valid_o <= 1'b0;
            q_last_o  <= 1'b0;
            q_short_o <= 1'b0;
        end else begin
            q_valid_o <= 1'b0;
            q_last_o  <= 1'b0;
            q_short_o <= 1'b0;
            if (clr_i) begin
                acc_q    <= '0;
                cnt_q    <= '0;
                hold_v_q <= 1'b0;
            end else if (sym_en_i) begin
                // a held quadlet is known not to be last once more data arrives
                if (hold_v_q) begin
                    q_data_o  <= hold_q;
                    q_valid_o <= 1'b1;
                    hold_v_q  <= 1'b0;
                end
                if (cnt_n == FULL) begin
                    hold_q   <= acc_n;
                    hold_v_q <= 1'b1;
                    acc_q    <= '0;
                    cnt_q    <= '0;
                end else begin
                    acc_q <= acc_n;
                    cnt_q <= cnt_n;
                end
            end else if (fin_i) begin
                if (hold_v_q) begin
                    q_data_o  <= hold_q;
                    q_valid_o <= 1'b1;
                    q_last_o  <= 1'b1;
                end else if (cnt_q != '0) begin
                    q_data_o  <= acc_q << (FULL - cnt_q);
                    q_valid_o <= 1'b1;
                    q_last_o  <= 1'b1;
                    q_short_o <= 1'b1;
                end
                acc_q    <= '0;
                cnt_q    <= '0;
                hold_v_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lnk_rx_deframer.sv
module lnk_rx_deframer
    import lnk_rx_pkg::*;
#(
    parameter int QUAD_W = 32,
    parameter int SYM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ctl_i,
    input  logic [SYM_W-1:0]  d_i,
    output logic [QUAD_W-1:0] q_data_o,
    output logic              q_valid_o,
    output logic              q_last_o,
    output logic              q_short_o,
    output logic              null_pkt_o,
    output logic              spd_err_o,
    output logic [1:0]        spd_o
);
    localparam int CNT_W = $clog2(QUAD_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PREFIX  = 2'd1,
        ST_PAYLOAD = 2'd2,
        ST_DISCARD = 2'd3
    } state_e;

    state_e           state_q, state_n;
    spd_e             spd_q, spd_dec;
    logic             rx, data_on;
    logic             pk_clr, pk_en, pk_fin, pk_empty;
    logic [CNT_W-1:0] nbits;

    assign rx      = (ctl_i == CTL_RECEIVE);
    assign data_on = (d_i == {SYM_W{1'b1}});

    lnk_rx_spd_dec #(.SYM_W(SYM_W)) u_dec (
        .sym_i (d_i),
        .spd_o (spd_dec)
    );

    assign nbits  = CNT_W'(spd_bits(spd_q));
    assign pk_clr = (state_q == ST_PREFIX) && rx && !data_on && (spd_dec != SPD_BAD);
    assign pk_en  = (state_q == ST_PAYLOAD) && rx;
    assign pk_fin = (state_q == ST_PAYLOAD) && !rx;

    lnk_rx_packer #(.QUAD_W(QUAD_W), .SYM_W(SYM_W), .CNT_W(CNT_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (pk_clr),
        .sym_en_i  (pk_en),
        .nbits_i   (nbits),
        .sym_i     (d_i),
        .fin_i     (pk_fin),
        .empty_o   (pk_empty),
        .q_data_o  (q_data_o),
        .q_valid_o (q_valid_o),
        .q_last_o  (q_last_o),
        .q_short_o (q_short_o)
    );

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:    if (rx && data_on) state_n = ST_PREFIX;
            ST_PREFIX: begin
                if (!rx)                    state_n = ST_IDLE;
                else if (data_on)           state_n = ST_PREFIX;
                else if (spd_dec == SPD_BAD) state_n = ST_DISCARD;
                else                        state_n = ST_PAYLOAD;
            end
            ST_PAYLOAD: if (!rx) state_n = ST_IDLE;
            ST_DISCARD: if (!rx) state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spd_q      <= SPD_S100;
            null_pkt_o <= 1'b0;
            spd_err_o  <= 1'b0;
        end else begin
            null_pkt_o <= 1'b0;
            spd_err_o  <= 1'b0;
            unique case (state_q)
                ST_PREFIX: begin
                    if (!rx) begin
                        null_pkt_o <= 1'b1;
                    end else if (!data_on) begin
                        if (spd_dec == SPD_BAD) spd_err_o <= 1'b1;
                        else                    spd_q     <= spd_dec;
                    end
                end
                ST_PAYLOAD: if (!rx && pk_empty) null_pkt_o <= 1'b1;
                default: ;
            endcase
        end
    end

    assign spd_o = spd_q;
endmodule

// File: rtl/lnk_rx_deframer_chk.sv
module lnk_rx_deframer_chk #(
    parameter int QUAD_W = 32,
    parameter int SYM_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        ctl_i,
    input logic [SYM_W-1:0]  d_i,
    input logic [QUAD_W-1:0] q_data_o,
    input logic              q_valid_o,
    input logic              q_last_o,
    input logic              q_short_o,
    input logic              null_pkt_o,
    input logic              spd_err_o,
    input logic [1:0]        spd_o
);
    // R5: last only on a valid beat
    a_r5_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        q_last_o |-> q_valid_o);

    // R6: short flag only on the final beat
    a_r6_short_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        q_short_o |-> q_last_o);

    // R7: a null packet, an error and a beat never coincide
    a_r7_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q_valid_o, null_pkt_o, spd_err_o}));

    // R8: nothing is emitted right after a bad speed code
    a_r8_discard_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        spd_err_o |=> !q_valid_o && !null_pkt_o);

    // R2: speed is steady inside a packet's quadlet stream
    a_r2_speed_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid_o && !q_last_o) |=> $stable(spd_o));

    // R5: beats follow recent Receive activity
    a_r5_beat_after_receive: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid_o |-> ($past(ctl_i) == 2'b10 || $past(ctl_i, 2) == 2'b10));

    // R2: speed value is one of the three legal encodings
    a_r2_speed_legal: assert property (@(posedge clk) disable iff (!rst_n)
        spd_o != 2'd3);
endmodule

bind lnk_rx_deframer lnk_rx_deframer_chk #(.QUAD_W(QUAD_W), .SYM_W(SYM_W)) u_chk (.*);

// File: tb/sim_lnk_rx_deframer.sv
module sim_lnk_rx_deframer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ctl_i = 2'b00;
    logic [7:0]  d_i = 8'h00;
    logic [31:0] q_data_o;
    logic        q_valid_o, q_last_o, q_short_o, null_pkt_o, spd_err_o;
    logic [1:0]  spd_o;

    int checks = 0, fails = 0;
    int cyc = 0, null_cnt = 0, err_cnt = 0;
    int last_cyc = -1, null_cyc = -1;
    logic [33:0] expq[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lnk_rx_deframer u0 (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl_i), .d_i(d_i),
        .q_data_o(q_data_o), .q_valid_o(q_valid_o), .q_last_o(q_last_o),
        .q_short_o(q_short_o), .null_pkt_o(null_pkt_o), .spd_err_o(spd_err_o),
        .spd_o(spd_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare every beat with the expected queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (q_valid_o) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R3 unexpected beat", {30'd0, q_last_o, q_short_o, q_data_o}, 64'd0);
                end else begin
                    logic [33:0] e;
                    e = expq.pop_front();
                    chk({q_last_o, q_short_o, q_data_o} == e, "R4 R6 beat content",
                        {30'd0, q_last_o, q_short_o, q_data_o}, {30'd0, e});
                end
                if (q_last_o) last_cyc = cyc;
            end
            if (null_pkt_o) begin null_cnt++; null_cyc = cyc; end
            if (spd_err_o) err_cnt++;
        end
    end

    function automatic int bits_of(input logic [7:0] code);
        case (code)
            8'h00: return 2;
            8'h40: return 4;
            8'h50: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic logic [1:0] spd_of(input logic [7:0] code);
        case (code)
            8'h40: return 2'd1;
            8'h50: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ctl_i = 2'b00;
            d_i = 8'($urandom);
        end
    endtask

    task automatic send_pkt(input bit with_code, input logic [7:0] code, input int n_on,
                            input int nsym, input logic [1:0] end_ctl);
        logic [7:0] syms[$];
        bit bits[$];
        int nb, full, rem, end_cyc, n0, e0;
        bit bad;
        logic [1:0] spd_before;
        nb = bits_of(code);
        bad = with_code && (nb == 0);
        spd_before = spd_o;
        for (int i = 0; i < nsym; i++) syms.push_back(8'($urandom));
        if (with_code && !bad)
            foreach (syms[i]) for (int b = 0; b < nb; b++) bits.push_back(syms[i][7-b]);
        full = bits.size() / 32;
        rem  = bits.size() % 32;
        for (int q = 0; q < full; q++) begin
            logic [31:0] w;
            for (int i = 0; i < 32; i++) w[31-i] = bits[q*32+i];
            expq.push_back({(q == full-1 && rem == 0), 1'b0, w});
        end
        if (rem > 0) begin
            logic [31:0] w = '0;
            for (int i = 0; i < rem; i++) w[31-i] = bits[full*32+i];
            expq.push_back({1'b1, 1'b1, w});
        end
        n0 = null_cnt; e0 = err_cnt;
        for (int i = 0; i < n_on; i++) begin
            @(negedge clk); ctl_i = 2'b10; d_i = 8'hFF;
        end
        if (with_code) begin
            @(negedge clk); ctl_i = 2'b10; d_i = code;
            foreach (syms[i]) begin
                @(negedge clk); ctl_i = 2'b10; d_i = syms[i];
            end
        end
        @(negedge clk); ctl_i = end_ctl; d_i = 8'($urandom);
        end_cyc = cyc;
        idle(4);
        chk(expq.size() == 0, "R3 R5 all expected beats seen", 64'(expq.size()), 64'd0);
        chk(err_cnt - e0 == int'(bad), "R8 error pulse count", 64'(err_cnt - e0), 64'(bad));
        chk(null_cnt - n0 == int'(!bad && bits.size() == 0), "R7 null pulse count",
            64'(null_cnt - n0), 64'(!bad && bits.size() == 0));
        if (!bad && bits.size() > 0)
            chk(last_cyc == end_cyc + 1, "R5 R10 last beat timing", 64'(last_cyc), 64'(end_cyc + 1));
        if (!bad && bits.size() == 0)
            chk(null_cyc == end_cyc + 1, "R7 null timing", 64'(null_cyc), 64'(end_cyc + 1));
        if (with_code && !bad)
            chk(spd_o == spd_of(code), "R2 speed decode", 64'(spd_o), 64'(spd_of(code)));
        else
            chk(spd_o == spd_before, "R2 R8 speed held", 64'(spd_o), 64'(spd_before));
        expq.delete();
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                chk(1'b0, "watchdog expired", 64'(wd), 64'd150000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] codes[3] = '{8'h00, 8'h40, 8'h50};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset values
        chk({q_valid_o, q_last_o, q_short_o, null_pkt_o, spd_err_o, spd_o} == 7'd0,
            "R9 reset state", {57'd0, q_valid_o, q_last_o, q_short_o, null_pkt_o, spd_err_o, spd_o}, 64'd0);
        rst_n = 1'b1;
        idle(2);
        // R1: Receive without data-on starts nothing
        begin
            int n0 = null_cnt, e0 = err_cnt;
            for (int i = 0; i < 3; i++) begin @(negedge clk); ctl_i = 2'b10; d_i = 8'h55; end
            idle(4);
            chk(null_cnt == n0 && err_cnt == e0, "R1 no start without data-on",
                64'(null_cnt - n0 + err_cnt - e0), 64'd0);
        end
        send_pkt(1, 8'h50, 1, 4, 2'b00);   // R5 exactly one full quadlet
        send_pkt(1, 8'h00, 2, 1, 2'b00);   // R6 two-bit partial
        send_pkt(1, 8'h40, 1, 9, 2'b01);   // R6 R10 full plus partial
        send_pkt(0, 8'h00, 3, 0, 2'b00);   // R7 null right after data-on
        send_pkt(1, 8'h40, 1, 0, 2'b11);   // R7 null right after speed code
        send_pkt(1, 8'h41, 1, 5, 2'b00);   // R8 bad code
        send_pkt(1, 8'h50, 1, 12, 2'b00);  // R8 recovery
        for (int p = 0; p < 60; p++) begin
            logic [7:0] c;
            c = ($urandom % 8 == 0) ? 8'h51 : codes[$urandom % 3];
            send_pkt(1, c, 1 + $urandom % 3, $urandom % 41, 2'($urandom % 2 == 0 ? 0 : 1 + $urandom % 3 == 2 ? 3 : 1));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule